// File: doc/BRIEF.md
# Paged Framebuffer Run Packer

This block holds a monochrome shadow image of 96 columns by 64 rows, one bit per pixel, for a display controller whose memory is organised in pages. Each stored byte covers one column across eight consecutive rows, so the image is eight pages of 96 bytes, or 768 bytes in all. A host works in horizontal runs instead: it names a row, a starting column and a pixel count, and then streams the run as packed bytes. The block turns each horizontal pixel into a read-modify-write of one bit in the matching column byte. On a read it does the opposite, packing page bits back into horizontal bytes.

One command is in flight at a time. A start strobe carries the opcode, row, column, length and a bit-order select. Write data arrives on a valid/ready byte stream, and read data leaves on a valid-only byte stream. A one-cycle done flag closes each command. A run that would cross the right edge is cut short. When a write completes, the block reports the page, the start column and the clipped length, so that a separate streamer can push exactly those bytes to the panel. A clear command walks the whole store and writes zero to every byte.

Top module: `fbp_run_packer`

## Requirements
- R1: While reset is held and directly after it, busy, done, err, in_ready, out_valid and dirty_valid are all 0.
- R2: A write run of effective length N changes, for each pixel i < N, only bit (row mod 8) of byte (row/8)*96 + col + i. A pixel value of 1 sets that bit and 0 clears it. Every other bit and byte keeps its value.
- R3: With msb_first=0, pixel i is bit (i mod 8) of input byte i/8. With msb_first=1, it is bit 7-(i mod 8). The same mapping packs read data.
- R4: The effective length N is len when col+len <= 96, and otherwise 96-col. A write accepts exactly ceil(N/8) input bytes.
- R5: A run is empty when N is 0 (len 0 or col >= 96) or when row >= 64. An empty write takes no input byte, leaves the store unchanged and finishes with err=0 and dirty_valid=0. An empty read returns no byte and finishes with err=1.
- R6: A read of N pixels emits ceil(N/8) bytes. Each byte starts at zero and gains a 1 for each set pixel, and a final partial byte has its unused bits at 0.
- R7: Opcode 2'b00 is write, 2'b01 is read, and 2'b10 or 2'b11 is clear. A clear sets all 768 bytes to 0x00 and then signals done with err=0.
- R8: When a non-empty write finishes, dirty_valid is 1 in the same cycle as done and carries page=row/8, the start column and N.
- R9: Every accepted command ends in exactly one done pulse lasting one cycle. A start raised while busy is ignored. Done follows the last pixel of a run on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, taken only while idle |
| op | input | 2 | 00 write, 01 read, 1x clear |
| row | input | 8 | Pixel row of the run |
| col | input | 8 | Starting column of the run |
| len | input | 8 | Requested pixel count |
| msb_first | input | 1 | Bit order inside packed bytes |
| in_valid | input | 1 | Write byte valid |
| in_data | input | 8 | Write byte |
| in_ready | output | 1 | Block takes in_data on this edge if in_valid |
| out_valid | output | 1 | Read byte valid, one cycle |
| out_data | output | 8 | Read byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Read run was empty (with done) |
| dirty_valid | output | 1 | Write finished with a changed span |
| dirty_page | output | 3 | Page of the changed span |
| dirty_col | output | 7 | First column of the changed span |
| dirty_len | output | 7 | Number of columns changed |

## Verification
The bench aims at the right-edge clip (a run starting at column 90 or 95, or asking for 200 pixels). A design with a wrong clip would take too many input bytes or write past the row into the next page. It also probes row 63 against row 64, since an off-by-one range test would let row 64 alias into page 8 past the store. Runs of 1, 5, 13 and 17 pixels in both bit orders catch a reversed lane or a lost final partial byte. Overlapping runs on neighbouring rows of one page, followed by a full read sweep, show whether a write touched bits or columns outside its own.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;

  localparam logic [1:0] OP_WRITE = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_RD   = 3'd2,
    ST_CLR  = 3'd3,
    ST_FIN  = 3'd4
  } fbp_state_e;

  // Pixels left on the line from col onward, capped by the request.
  function automatic int clip_len(int col, int req, int cols);
    if (col >= cols) return 0;
    if (col + req > cols) return cols - col;
    return req;
  endfunction

  // Bit lane inside a packed host byte for pixel index idx.
  function automatic logic [2:0] lane_of(logic [2:0] idx, logic msb);
    return msb ? (3'd7 - idx) : idx;
  endfunction

  // Store address of the first column byte of a run.
  function automatic int base_of(int page, int col, int cols);
    return page * cols + col;
  endfunction

endpackage

// File: rtl/fbp_clip.sv
`timescale 1ns/1ps
module fbp_clip #(
  parameter int COLS  = 96,
  parameter int ROWS  = 64,
  parameter int CRD_W = 8,
  parameter int LW    = 7,
  parameter int PW    = 3
) (
  input  logic [CRD_W-1:0] row,
  input  logic [CRD_W-1:0] col,
  input  logic [CRD_W-1:0] len,
  output logic             run_ok,
  output logic [LW-1:0]    eff_len,
  output logic [PW-1:0]    page,
  output logic [2:0]       row_lane
);
  int eff_i;

  always_comb begin
    eff_i    = fbp_pkg::clip_len(int'(col), int'(len), COLS);
    eff_len  = LW'(eff_i);
    run_ok   = (int'(row) < ROWS) && (eff_i != 0);
    page     = PW'(row >> 3);
    row_lane = row[2:0];
  end
endmodule

// File: rtl/fbp_store.sv
`timescale 1ns/1ps
module fbp_store #(
  parameter int DEPTH = 768,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/fbp_ctrl.sv
`timescale 1ns/1ps
module fbp_ctrl
  import fbp_pkg::*;
#(
  parameter int COLS  = 96,
  parameter int PAGES = 8,
  parameter int LW    = 7,
  parameter int PW    = 3,
  parameter int XW    = 7,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          run_ok,
  input  logic [LW-1:0] eff_len,
  input  logic [PW-1:0] page,
  input  logic [2:0]    row_lane,
  input  logic [XW-1:0] col,
  input  logic          msb_first,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          dirty_valid,
  output logic [PW-1:0] dirty_page,
  output logic [XW-1:0] dirty_col,
  output logic [LW-1:0] dirty_len,
  output logic          pix_fire,
  output logic          run_last
);
  localparam int DEPTH = COLS * PAGES;

  fbp_state_e    state_q;
  logic [AW-1:0] cnt_q, base_q;
  logic [LW-1:0] len_q;
  logic [PW-1:0] page_q;
  logic [XW-1:0] col_q;
  logic [2:0]    rlane_q;
  logic          msb_q, have_q, err_q, ok_q, wr_op_q, ov_q;
  logic [7:0]    cur_q, acc_q, od_q;

  logic [2:0] pix_idx, lane;
  logic       byte_end, wr_fire, rd_fire, clr_last;
  logic [7:0] pix_byte, row_mask, acc_next;

  always_comb begin
    pix_idx  = cnt_q[2:0];
    lane     = lane_of(pix_idx, msb_q);
    run_last = (cnt_q == (AW'(len_q) - AW'(1)));
    byte_end = (pix_idx == 3'd7) || run_last;
    clr_last = (cnt_q == AW'(DEPTH - 1));
    pix_byte = have_q ? cur_q : in_data;
    row_mask = 8'd1 << rlane_q;
    in_ready = (state_q == ST_WR) && !have_q;
    wr_fire  = (state_q == ST_WR) && (have_q || in_valid);
    rd_fire  = (state_q == ST_RD);
    pix_fire = wr_fire || rd_fire;
    acc_next = mem_rdata[rlane_q] ? (acc_q | (8'd1 << lane)) : acc_q;
    mem_we   = wr_fire || (state_q == ST_CLR);
    mem_addr = (state_q == ST_CLR) ? cnt_q : (base_q + cnt_q);
    if (state_q == ST_CLR)
      mem_wdata = 8'h00;
    else if (pix_byte[lane])
      mem_wdata = mem_rdata | row_mask;
    else
      mem_wdata = mem_rdata & ~row_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      len_q   <= '0;
      page_q  <= '0;
      col_q   <= '0;
      rlane_q <= '0;
      msb_q   <= 1'b0;
      have_q  <= 1'b0;
      err_q   <= 1'b0;
      ok_q    <= 1'b0;
      wr_op_q <= 1'b0;
      ov_q    <= 1'b0;
      cur_q   <= '0;
      acc_q   <= '0;
      od_q    <= '0;
    end else begin
      ov_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            cnt_q   <= '0;
            have_q  <= 1'b0;
            acc_q   <= '0;
            len_q   <= eff_len;
            page_q  <= page;
            col_q   <= col;
            rlane_q <= row_lane;
            msb_q   <= msb_first;
            base_q  <= AW'(base_of(int'(page), int'(col), COLS));
            wr_op_q <= (op == OP_WRITE);
            if (op[1]) begin
              state_q <= ST_CLR;
              err_q   <= 1'b0;
              ok_q    <= 1'b0;
            end else if (!run_ok) begin
              state_q <= ST_FIN;
              err_q   <= (op == OP_READ);
              ok_q    <= 1'b0;
            end else begin
              state_q <= (op == OP_READ) ? ST_RD : ST_WR;
              err_q   <= 1'b0;
              ok_q    <= 1'b1;
            end
          end
        end
        ST_WR: begin
          if (wr_fire) begin
            cnt_q  <= cnt_q + AW'(1);
            have_q <= !byte_end;
            if (!have_q) cur_q <= in_data;
            if (run_last) state_q <= ST_FIN;
          end
        end
        ST_RD: begin
          cnt_q <= cnt_q + AW'(1);
          if (byte_end) begin
            ov_q  <= 1'b1;
            od_q  <= acc_next;
            acc_q <= '0;
          end else begin
            acc_q <= acc_next;
          end
          if (run_last) state_q <= ST_FIN;
        end
        ST_CLR: begin
          cnt_q <= cnt_q + AW'(1);
          if (clr_last) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_FIN);
  assign err         = done && err_q;
  assign dirty_valid = done && ok_q && wr_op_q;
  assign dirty_page  = page_q;
  assign dirty_col   = col_q;
  assign dirty_len   = len_q;
  assign out_valid   = ov_q;
  assign out_data    = od_q;
endmodule

// File: rtl/fbp_run_packer.sv
`timescale 1ns/1ps
module fbp_run_packer #(
  parameter int COLS  = 96,
  parameter int ROWS  = 64,
  parameter int CRD_W = 8,
  localparam int PAGES = ROWS / 8,
  localparam int LW    = $clog2(COLS + 1),
  localparam int XW    = $clog2(COLS),
  localparam int PW    = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [CRD_W-1:0] row,
  input  logic [CRD_W-1:0] col,
  input  logic [CRD_W-1:0] len,
  input  logic             msb_first,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             dirty_valid,
  output logic [PW-1:0]    dirty_page,
  output logic [XW-1:0]    dirty_col,
  output logic [LW-1:0]    dirty_len
);
  localparam int DEPTH = COLS * PAGES;
  localparam int AW    = $clog2(DEPTH);

  logic          run_ok;
  logic [LW-1:0] eff_len;
  logic [PW-1:0] page;
  logic [2:0]    row_lane;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          pix_fire, run_last;

  fbp_clip #(.COLS(COLS), .ROWS(ROWS), .CRD_W(CRD_W), .LW(LW), .PW(PW)) u_clip (
    .row(row), .col(col), .len(len),
    .run_ok(run_ok), .eff_len(eff_len), .page(page), .row_lane(row_lane)
  );

  fbp_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );

  fbp_ctrl #(.COLS(COLS), .PAGES(PAGES), .LW(LW), .PW(PW), .XW(XW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .run_ok(run_ok), .eff_len(eff_len), .page(page), .row_lane(row_lane),
    .col(XW'(col)), .msb_first(msb_first),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .out_valid(out_valid), .out_data(out_data),
    .busy(busy), .done(done), .err(err),
    .dirty_valid(dirty_valid), .dirty_page(dirty_page),
    .dirty_col(dirty_col), .dirty_len(dirty_len),
    .pix_fire(pix_fire), .run_last(run_last)
  );
endmodule

// File: rtl/fbp_run_packer_chk.sv
`timescale 1ns/1ps
module fbp_run_packer_chk #(
  parameter int COLS = 96,
  parameter int LW   = 7,
  parameter int XW   = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          in_ready,
  input logic          out_valid,
  input logic          dirty_valid,
  input logic [XW-1:0] dirty_col,
  input logic [LW-1:0] dirty_len,
  input logic          pix_fire,
  input logic          run_last
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);  // R9

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fire && run_last) |=> done);  // R9

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);  // R5

  AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !done));  // R2

  AST_OUT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);  // R6

  AST_DIRTY_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |-> (dirty_len != '0 && (int'(dirty_col) + int'(dirty_len)) <= COLS));  // R4

  AST_DIRTY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |-> (done && !err));  // R8
endmodule

bind fbp_run_packer fbp_run_packer_chk #(.COLS(COLS), .LW(LW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .in_ready(in_ready), .out_valid(out_valid), .dirty_valid(dirty_valid),
  .dirty_col(dirty_col), .dirty_len(dirty_len),
  .pix_fire(pix_fire), .run_last(run_last)
);

// File: tb/fbp_run_packer_bench.sv
`timescale 1ns/1ps
module fbp_run_packer_bench;
  localparam int COLS = 96;
  localparam int ROWS = 64;
  localparam int DEPTH = COLS * ROWS / 8;
  localparam int NVEC = 9;
  // row[31:24] col[23:16] len[15:8] seed[7:1] msb[0]
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_6022, 32'h2D0A_0D47, 32'h3F5A_146A, 32'h075F_0105, 32'h0803_0880,
    32'h2128_1133, 32'h2D0C_05FE, 32'h1400_C855, 32'h2E08_141E
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] row = '0, col = '0, len = '0;
  logic msb_first = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, busy, done, err, dirty_valid;
  logic [7:0] out_data;
  logic [2:0] dirty_page;
  logic [6:0] dirty_col, dirty_len;

  always #10 clk = ~clk;

  fbp_run_packer u_fbp_run_packer (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .row(row), .col(col), .len(len),
    .msb_first(msb_first), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .busy(busy), .done(done), .err(err),
    .dirty_valid(dirty_valid), .dirty_page(dirty_page), .dirty_col(dirty_col),
    .dirty_len(dirty_len)
  );

  logic [7:0] model [DEPTH];
  int total = 0;
  int bad = 0;

  task automatic check_eq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int span(int c, int l);
    int room;
    room = COLS - c;
    if (room <= 0) return 0;
    return (l < room) ? l : room;
  endfunction

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 7 + k * 91 + 13) ^ (k << 3));
  endfunction

  task automatic issue(logic [1:0] o, int r, int c, int l, bit m);
    @(negedge clk);
    start = 1'b1; op = o; row = 8'(r); col = 8'(c); len = 8'(l); msb_first = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_write(int r, int c, int l, bit m, int seed, string req);
    int n, k, guard, nbytes;
    bit seen, ok;
    logic [7:0] b;
    n = span(c, l);
    ok = (r < ROWS) && (n > 0);
    nbytes = ok ? (n + 7) / 8 : 0;
    issue(2'b00, r, c, l, m);
    k = 0; guard = 0; seen = 0;
    while (!seen && guard < 2000) begin
      if (done) begin
        seen = 1;
        in_valid = 1'b0;
        check_eq(req, "write dirty_valid (R8)", int'(dirty_valid), int'(ok));
        check_eq(req, "write err", int'(err), 0);
        if (ok) begin
          check_eq("R8", "dirty_page", int'(dirty_page), r / 8);
          check_eq("R8", "dirty_col", int'(dirty_col), c);
          check_eq("R4", "dirty_len", int'(dirty_len), n);
        end
      end else begin
        if (in_ready) begin
          in_valid = 1'b1;
          in_data = pat(seed, k);
          k++;
        end else begin
          in_valid = 1'b0;
        end
        @(negedge clk);
        guard++;
      end
    end
    check_eq(req, "write finished", int'(seen), 1);
    check_eq("R4", "input bytes taken", k, nbytes);
    if (ok) begin
      for (int i = 0; i < n; i++) begin
        int a;
        b = pat(seed, i / 8);
        a = (r / 8) * COLS + c + i;
        model[a][r % 8] = b[m ? 7 - (i % 8) : (i % 8)];
      end
    end
    @(negedge clk);
    check_eq("R9", "done lasts one cycle", int'(done), 0);
  endtask

  task automatic do_read(int r, int c, int l, bit m, string req);
    int n, nb, guard, nexp;
    bit seen, ok, e;
    logic [7:0] got [16];
    logic [7:0] exp_b;
    n = span(c, l);
    ok = (r < ROWS) && (n > 0);
    nexp = ok ? (n + 7) / 8 : 0;
    issue(2'b01, r, c, l, m);
    nb = 0; guard = 0; seen = 0; e = 0;
    while (!seen && guard < 2000) begin
      if (out_valid) begin
        if (nb < 16) got[nb] = out_data;
        nb++;
      end
      if (done) begin
        seen = 1;
        e = err;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    check_eq(req, "read finished", int'(seen), 1);
    check_eq(ok ? req : "R5", "read err", int'(e), int'(!ok));
    check_eq(req, "read byte count", nb, nexp);
    for (int j = 0; j < nexp && j < nb && j < 16; j++) begin
      exp_b = 8'h00;
      for (int p = 0; p < 8; p++) begin
        int i;
        i = j * 8 + p;
        if (i < n && model[(r / 8) * COLS + c + i][r % 8])
          exp_b[m ? 7 - p : p] = 1'b1;
      end
      check_eq(req, $sformatf("read byte %0d row %0d", j, r), int'(got[j]), int'(exp_b));
    end
    @(negedge clk);
  endtask

  task automatic do_clear(logic [1:0] o);
    int guard;
    issue(o, 0, 0, 0, 1'b0);
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check_eq("R7", "clear finished", int'(done), 1);
    check_eq("R7", "clear err", int'(err), 0);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
    @(negedge clk);
  endtask

  task automatic sweep(string req);
    for (int r = 0; r < ROWS; r++) do_read(r, 0, COLS, r[0], req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int guard;
    repeat (2) @(negedge clk);
    // R1: outputs quiet under reset
    check_eq("R1", "busy in reset", int'(busy), 0);
    check_eq("R1", "done in reset", int'(done), 0);
    check_eq("R1", "in_ready in reset", int'(in_ready), 0);
    check_eq("R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "dirty_valid after reset", int'(dirty_valid), 0);
    check_eq("R1", "err after reset", int'(err), 0);
    check_eq("R1", "busy after reset", int'(busy), 0);

    do_clear(2'b10);
    sweep("R7");

    for (int v = 0; v < NVEC; v++) begin
      int r, c, l, s;
      bit m;
      r = int'(VEC[v][31:24]);
      c = int'(VEC[v][23:16]);
      l = int'(VEC[v][15:8]);
      s = int'(VEC[v][7:1]);
      m = VEC[v][0];
      do_write(r, c, l, m, s, "R2");
      do_read(r, c, l, m, m ? "R3" : "R6");
    end

    // R5: empty runs are ignored on write and flagged on read
    do_write(64, 0, 5, 1'b0, 3, "R5");
    do_write(10, 96, 4, 1'b1, 4, "R5");
    do_write(12, 20, 0, 1'b0, 5, "R5");
    do_read(64, 0, 8, 1'b0, "R5");
    do_read(5, 96, 8, 1'b0, "R5");
    do_read(5, 10, 0, 1'b1, "R5");
    do_read(63, 95, 1, 1'b0, "R4");

    // R2: full sweep shows nothing outside the runs changed
    sweep("R2");

    // R9: start while clearing is ignored; opcode 2'b11 clears (R7)
    issue(2'b11, 0, 0, 0, 1'b0);
    repeat (3) @(negedge clk);
    start = 1'b1; op = 2'b01; row = 8'd0; col = 8'd0; len = 8'd8;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check_eq("R7", "alt clear finished", int'(done), 1);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      check_eq("R9", "no extra done", int'(done), 0);
      check_eq("R9", "no stray read byte", int'(out_valid), 0);
    end
    sweep("R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule